// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counter channels. Each keeps its count as a low byte and a high byte that software can read and write. A channel advances on one of two kinds of event. The first is a tick of an internal time base, which divides the clock by 12 (the reset choice) or by 4. The second is a falling edge on the channel's external input, which is synchronised into the clock domain before it is used. A run bit in the control register gates each channel. When a channel overflows, its sticky flag is set, and that flag is driven straight onto a port.

A per-channel mode field selects how the count is built:
- a 13-bit count, where the low byte's lower five bits act as a prescaler into the high byte;
- a full 16-bit count;
- an 8-bit count whose low byte reloads from the high byte when it overflows;
- on channel 0 only, a split mode that forms two independent 8-bit counters with no reload.

In split mode, channel 0's upper counter runs from channel 0's time base. It is gated by channel 1's run bit and reports through channel 1's flag. Channel 1 set to that same mode code simply holds its count.

Register addresses:

| Address | Register |
|---|---|
| 0 | mode |
| 1 | control |
| 2 | channel 0 low byte |
| 3 | channel 0 high byte |
| 4 | channel 1 low byte |
| 5 | channel 1 high byte |

Top module: `tmr_pair`

## Requirements
- R1: After reset, every register reads 0x00 and both flags are 0. This means mode code 0 (13-bit), the internal source, divide-by-12 and both channels stopped.
- R2: A write with wr_en high stores wr_data into the register at addr on the next rising edge. A read returns it combinationally on rd_data. The mode register holds channel 0 in bits [3:0] and channel 1 in bits [7:4]. Within each nibble, bits [1:0] are the mode (0=13-bit, 1=16-bit, 2=8-bit reload, 3=split), bit 2 selects the external source and bit 3 selects divide-by-4. Addresses 6 and 7 read 0x00.
- R3: In mode 1, the count {high,low} steps by one per event and wraps from 0xFFFF to 0x0000, setting the channel's flag.
- R4: In mode 0, the count is {high, low[4:0]}. low[7:5] is left unchanged. Stepping from high=0xFF, low[4:0]=0x1F gives zero and sets the flag.
- R5: In mode 2, only the low byte steps. When it steps from 0xFF, it loads the high byte and sets the flag. The high byte never changes on its own.
- R6: In mode 3, channel 0's low byte is an 8-bit counter driven by channel 0's source and run bit. It wraps from 0xFF to 0x00 with no reload and sets flag 0.
- R7: In mode 3, channel 0's high byte counts channel 0's internal time base while run bit 1 is set. Its wrap from 0xFF sets flag 1. While channel 0 is in mode 3, channel 1's own overflow does not set flag 1.
- R8: Channel 1 in mode 3 holds its count whatever its run bit and input do.
- R9: With the external source selected, the count steps once per 1-to-0 transition of ext_in. The step shows after the third rising clock edge that samples the input low. A held level or a rising edge adds nothing.
- R10: With the internal source, a channel steps once per 12 clocks while running, or once per 4 clocks when its divide-by-4 bit is set.
- R11: The control register holds run bits in bits [1:0] and flags in bits [3:2]. A flag is sticky. Writing 0 to a flag bit clears it and writing 1 leaves it unchanged. An overflow in the same cycle as a clearing write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for addr |
| ext_in | input | 2 | External event inputs, one per channel |
| ovf_flag | output | 2 | Sticky overflow flags, one per channel |

## Verification
Two functions can land in the same cycle: a channel overflow, and a software write to the control register that clears that channel's flag. The bench arranges this by holding a 16-bit count at 0xFFFF and dropping the external input. It then times the clearing write so that it lands on the third edge after the drop, which is exactly the edge that counts the event. The result is judged at the ports. The flag must still read set and the count must read 0x0000. A later plain clearing write must then bring the flag to zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    TM_13    = 2'd0,
    TM_16    = 2'd1,
    TM_8R    = 2'd2,
    TM_SPLIT = 2'd3
  } tmode_e;

  typedef struct packed {
    logic [7:0] hi;
    logic [7:0] lo;
    logic       ovf;
  } cnt_s;

  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_LO0  = 3'd2;
  localparam logic [2:0] A_HI0  = 3'd3;
  localparam logic [2:0] A_LO1  = 3'd4;
  localparam logic [2:0] A_HI1  = 3'd5;

  // One count step of a channel in the given mode; split mode covers the low byte only.
  function automatic cnt_s step_count(tmode_e m, logic [7:0] hi, logic [7:0] lo);
    cnt_s r;
    logic [13:0] v13;
    logic [16:0] v16;
    r = '{hi: hi, lo: lo, ovf: 1'b0};
    case (m)
      TM_13: begin
        v13   = {1'b0, hi, lo[4:0]} + 14'd1;
        r.hi  = v13[12:5];
        r.lo  = {lo[7:5], v13[4:0]};
        r.ovf = v13[13];
      end
      TM_16: begin
        v16   = {1'b0, hi, lo} + 17'd1;
        r.hi  = v16[15:8];
        r.lo  = v16[7:0];
        r.ovf = v16[16];
      end
      TM_8R: begin
        if (lo == 8'hFF) begin
          r.lo  = hi;
          r.ovf = 1'b1;
        end else begin
          r.lo = lo + 8'd1;
        end
      end
      default: begin
        r.lo  = lo + 8'd1;
        r.ovf = (lo == 8'hFF);
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tmr_presc.sv
module tmr_presc #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);

  generate
    if (DIV > 1) begin : g_gap
      // R10
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/tmr_edge.sv
module tmr_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              s_last;

  assign s_last = sync_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= s_last;
    end
  end

  assign fall = prev_q & ~s_last;

  // R9
  fall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter bit HAS_SPLIT = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  tmode_e     mode,
  input  logic       inc,
  input  logic       inc_hi,
  input  logic       wr_lo,
  input  logic       wr_hi,
  input  logic [7:0] wdata,
  output logic [7:0] lo,
  output logic [7:0] hi,
  output logic       ovf_lo,
  output logic       ovf_hi
);
  cnt_s nx;
  logic split, hold, lo_blk, lo_step, hi_step;

  assign nx      = step_count(mode, hi, lo);
  assign split   = HAS_SPLIT && (mode == TM_SPLIT);
  assign hold    = !HAS_SPLIT && (mode == TM_SPLIT);
  assign lo_blk  = split ? wr_lo : (wr_lo | wr_hi);
  assign lo_step = inc && !hold && !lo_blk;
  assign hi_step = split && inc_hi && !wr_hi;
  assign ovf_lo  = lo_step && nx.ovf;
  assign ovf_hi  = hi_step && (hi == 8'hFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else begin
      if (wr_lo)        lo <= wdata;
      else if (lo_step) lo <= nx.lo;
      if (wr_hi)        hi <= wdata;
      else if (hi_step) hi <= hi + 8'd1;
      else if (lo_step) hi <= nx.hi;
    end
  end

  // R3
  wrap16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_step && mode == TM_16 && {hi, lo} == 16'hFFFF) |=> ({hi, lo} == 16'h0000));

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_step && mode == TM_8R && lo == 8'hFF && !wr_hi) |=> (lo == $past(hi) && $stable(hi)));

  generate
    if (!HAS_SPLIT) begin : g_hold
      // R8
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_SPLIT && !wr_lo && !wr_hi) |=> ($stable(lo) && $stable(hi)));
    end
  endgenerate
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int DIV_SLOW    = 12,
  parameter int DIV_FAST    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic [1:0] ext_in,
  output logic [1:0] ovf_flag
);
  localparam int NCH = 2;

  logic [7:0]     mode_q;
  logic [NCH-1:0] run_q, flag_q;
  logic           tick_slow, tick_fast, split0, ctrl_wr;
  logic [NCH-1:0] fall, tb, inc, ovf_lo, ovf_hi, set_flag;
  logic [7:0]     lo [NCH];
  logic [7:0]     hi [NCH];
  tmode_e         cmode [NCH];

  tmr_presc #(.DIV(DIV_SLOW)) u_slow (.clk(clk), .rst_n(rst_n), .tick(tick_slow));
  tmr_presc #(.DIV(DIV_FAST)) u_fast (.clk(clk), .rst_n(rst_n), .tick(tick_fast));

  assign ctrl_wr = wr_en && (addr == A_CTRL);
  assign split0  = (cmode[0] == TM_SPLIT);

  generate
    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
      logic [3:0] nib;
      assign nib       = mode_q[4*gi +: 4];
      assign cmode[gi] = tmode_e'(nib[1:0]);
      assign tb[gi]    = nib[3] ? tick_fast : tick_slow;
      assign inc[gi]   = run_q[gi] && (nib[2] ? fall[gi] : tb[gi]);

      tmr_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin(ext_in[gi]), .fall(fall[gi]));

      tmr_chan #(.HAS_SPLIT(gi == 0)) u_chan (
        .clk(clk), .rst_n(rst_n), .mode(cmode[gi]), .inc(inc[gi]),
        .inc_hi((gi == 0) && run_q[1] && tb[0]),
        .wr_lo(wr_en && addr == 3'(A_LO0 + 2*gi)),
        .wr_hi(wr_en && addr == 3'(A_HI0 + 2*gi)),
        .wdata(wr_data), .lo(lo[gi]), .hi(hi[gi]),
        .ovf_lo(ovf_lo[gi]), .ovf_hi(ovf_hi[gi]));
    end
  endgenerate

  assign set_flag[0] = ovf_lo[0];
  assign set_flag[1] = split0 ? ovf_hi[0] : ovf_lo[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr_en && addr == A_MODE) mode_q <= wr_data;
      if (ctrl_wr) begin
        run_q  <= wr_data[1:0];
        flag_q <= (flag_q & wr_data[3:2]) | set_flag;
      end else begin
        flag_q <= flag_q | set_flag;
      end
    end
  end

  always_comb begin
    case (addr)
      A_MODE:  rd_data = mode_q;
      A_CTRL:  rd_data = {4'b0, flag_q, run_q};
      A_LO0:   rd_data = lo[0];
      A_HI0:   rd_data = hi[0];
      A_LO1:   rd_data = lo[1];
      A_HI1:   rd_data = hi[1];
      default: rd_data = 8'h00;
    endcase
  end

  assign ovf_flag = flag_q;

  // R11
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_flag[0] |=> ovf_flag[0]);
  // R11
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag[1] && !ctrl_wr) |=> ovf_flag[1]);
  // R7
  split_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (split0 && ovf_hi[0]) |=> ovf_flag[1]);
endmodule

// File: tb/tmr_pair_bench.sv
module tmr_pair_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] ext_in = 2'b11;
  logic [1:0] ovf_flag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  tmr_pair u_tmr_pair (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .ext_in(ext_in), .ovf_flag(ovf_flag));

  typedef struct packed {
    logic [1:0] m;
    logic [7:0] lo;
    logic [7:0] hi;
    logic [3:0] np;
    logic [7:0] elo;
    logic [7:0] ehi;
    logic       ef;
  } vec_t;

  // Channel 0, external source. R3 mode 1, R4 mode 0, R5 mode 2, R6 mode 3.
  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 8'hFE, 8'h12, 4'd3, 8'h01, 8'h13, 1'b0},
    '{2'd1, 8'hFF, 8'hFF, 4'd1, 8'h00, 8'h00, 1'b1},
    '{2'd0, 8'h1E, 8'h05, 4'd3, 8'h01, 8'h06, 1'b0},
    '{2'd0, 8'hFF, 8'hFF, 4'd1, 8'hE0, 8'h00, 1'b1},
    '{2'd2, 8'hFD, 8'h80, 4'd4, 8'h81, 8'h80, 1'b1},
    '{2'd2, 8'h10, 8'h33, 4'd2, 8'h12, 8'h33, 1'b0},
    '{2'd3, 8'hFF, 8'h44, 4'd1, 8'h00, 8'h44, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic pulse(input int ch);
    @(negedge clk); ext_in[ch] = 1'b0;
    repeat (2) @(negedge clk);
    ext_in[ch] = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic window(input logic [7:0] on, input logic [7:0] off, input int n);
    wr(A_CTRL_B, on);
    repeat (n - 1) @(posedge clk);
    wr(A_CTRL_B, off);
  endtask

  localparam logic [2:0] A_MODE_B = 3'd0;
  localparam logic [2:0] A_CTRL_B = 3'd1;

  task automatic rd16(input logic [2:0] a_lo, output logic [15:0] v);
    logic [7:0] l, h;
    rd(a_lo, l);
    rd(a_lo + 3'd1, h);
    v = {h, l};
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin : main
    logic [7:0]  b;
    logic [15:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), b);
      chk("R1 reg", {8'h00, b}, 16'h0000);
    end
    chk("R1 flags", {14'b0, ovf_flag}, 16'h0000);

    // R2 write and read back
    wr(A_MODE_B, 8'hA5); rd(A_MODE_B, b); chk("R2 mode", {8'h00, b}, 16'h00A5);
    wr(3'd4, 8'h3C);     rd(3'd4, b);     chk("R2 lo1", {8'h00, b}, 16'h003C);
    rd(3'd7, b); chk("R2 unmapped", {8'h00, b}, 16'h0000);

    // Vector table: R3, R4, R5, R6
    for (int i = 0; i < NV; i++) begin
      wr(A_MODE_B, {4'h0, 2'b01, VECS[i].m});
      wr(3'd2, VECS[i].lo);
      wr(3'd3, VECS[i].hi);
      wr(A_CTRL_B, 8'h01);
      for (int p = 0; p < int'(VECS[i].np); p++) pulse(0);
      rd16(3'd2, v);
      chk($sformatf("R%0s vec%0d count", VECS[i].m == 2'd0 ? "4" : VECS[i].m == 2'd1 ? "3" :
          VECS[i].m == 2'd2 ? "5" : "6", i), v, {VECS[i].ehi, VECS[i].elo});
      chk("R11 vec flag0", {15'b0, ovf_flag[0]}, {15'b0, VECS[i].ef});
      chk("R6 vec flag1", {15'b0, ovf_flag[1]}, 16'h0000);
    end

    // R9 latency and edge only
    wr(A_MODE_B, 8'h05); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(A_CTRL_B, 8'h01);
    @(negedge clk); ext_in[0] = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    rd16(3'd2, v); chk("R9 before third edge", v, 16'h0000);
    @(posedge clk); #1;
    rd16(3'd2, v); chk("R9 after third edge", v, 16'h0001);
    repeat (6) @(negedge clk);
    ext_in[0] = 1'b1;
    repeat (5) @(negedge clk);
    rd16(3'd2, v); chk("R9 level and rise", v, 16'h0001);

    // R11 overflow and clearing write in the same cycle
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(A_CTRL_B, 8'h01);
    @(negedge clk); ext_in[0] = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); wr_en = 1'b1; addr = A_CTRL_B; wr_data = 8'h01;
    @(posedge clk); #1 wr_en = 1'b0;
    chk("R11 collision flag", {15'b0, ovf_flag[0]}, 16'h0001);
    rd16(3'd2, v); chk("R3 collision wrap", v, 16'h0000);
    @(negedge clk); ext_in[0] = 1'b1;
    wr(A_CTRL_B, 8'h0D);
    chk("R11 write one keeps", {15'b0, ovf_flag[0]}, 16'h0001);
    wr(A_CTRL_B, 8'h00);
    chk("R11 clear", {15'b0, ovf_flag[0]}, 16'h0000);

    // R10 time base
    wr(A_MODE_B, 8'h01); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    window(8'h01, 8'h00, 120);
    rd16(3'd2, v); chk("R10 div12 ch0", v, 16'd10);
    wr(A_MODE_B, 8'h09); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    window(8'h01, 8'h00, 120);
    rd16(3'd2, v); chk("R10 div4 ch0", v, 16'd30);
    wr(A_MODE_B, 8'h10); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    window(8'h02, 8'h00, 48);
    rd16(3'd4, v); chk("R10 div12 ch1", v, 16'd4);

    // R7 split upper counter and flag ownership
    wr(A_MODE_B, 8'h53);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    wr(A_CTRL_B, 8'h02);
    pulse(1);
    rd16(3'd4, v); chk("R7 ch1 wraps", v, 16'h0000);
    chk("R7 ch1 no flag", {15'b0, ovf_flag[1]}, 16'h0000);
    wr(A_CTRL_B, 8'h00);
    wr(3'd3, 8'hFF);
    window(8'h02, 8'h0C, 12);
    rd16(3'd2, v); chk("R7 upper wrap", v, 16'h0000);
    chk("R7 flag1", {15'b0, ovf_flag[1]}, 16'h0001);
    chk("R7 flag0 untouched", {15'b0, ovf_flag[0]}, 16'h0000);

    // R8 channel 1 in mode 3 holds
    wr(A_MODE_B, 8'h70); wr(3'd4, 8'h55); wr(3'd5, 8'h66); wr(A_CTRL_B, 8'h02);
    pulse(1); pulse(1);
    repeat (30) @(negedge clk);
    rd16(3'd4, v); chk("R8 hold", v, 16'h6655);
    chk("R8 no flag", {15'b0, ovf_flag[1]}, 16'h0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule